// File: doc/BRIEF.md
# Accelerated Open-Drain Pad Controller

This block drives a group of bidirectional pads so that each behaves as an open-drain output with an external pull-up to a higher supply. A low data bit turns the driver on and pulls the line low. A high data bit normally leaves the driver off, so the pull-up sets the level. After each low-to-high change of a data bit, the channel briefly drives the line high at full strength, which shortens the slow resistive rise, and then lets go. The pad data pin always carries the data bit. The open-drain behaviour comes only from how the output enable is gated.

There are two ways to end the strong-high burst, chosen by one shared mode input. In direct mode the raw pad feedback is used, and the driver turns off in the same cycle the line reads high. In clocked mode the feedback passes through a two-flop synchronizer, so the burst length is set in whole clocks. In both modes a per-channel counter stops the burst after a programmable number of clocks. This keeps a channel from fighting another device that holds a shared wired-OR line low. All pins are plain level signals with no handshake: inputs are used in the cycle they are presented, and nothing is ever held back.

Top module: `qod_accel`

## Requirements
- R1: When a channel's data bit is 0 and reset is not asserted, its pad_oe is 1 and its pad_do is 0 in the same cycle.
- R2: Outside reset, pad_do equals data_in on every channel in every cycle.
- R3: While rst is 1, every pad_oe is 0 and every pad_do is 1. After reset, a channel whose data bit is already 1 does not drive until its data bit has gone to 0 and back to 1.
- R4: With mode_sel = 0 (direct), after a 0-to-1 data change, pad_oe stays 1 while pad_fb reads 0. It drops to 0 in the same cycle pad_fb reads 1.
- R5: With mode_sel = 1 (clocked) and drive_cap = 1, a 0-to-1 data change on a low line gives exactly one clock of pad_oe = 1 with pad_do = 1.
- R6: In clocked mode the burst ends on the feedback only after it has crossed a two-flop synchronizer. A pad_fb that rises in the cycle the data rises still allows two clocks of high drive.
- R7: In either mode, consecutive high-drive cycles (pad_oe = 1 and pad_do = 1) never exceed drive_cap, even while pad_fb stays 0.
- R8: Once a burst has ended, a channel whose data bit stays 1 does not drive high again, even if the line is later pulled low.
- R9: With drive_cap = 0 no channel ever drives high, in either mode: plain open-drain.
- R10: Channels are independent. Each channel's burst starts and ends on its own data bit and its own feedback bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all channels |
| rst | input | 1 | Synchronous active-high reset; forces all channels released |
| mode_sel | input | 1 | 0 = direct feedback, 1 = synchronized (clocked) feedback |
| drive_cap | input | CAP_W | Maximum number of clocks of strong-high drive per burst |
| data_in | input | N_CH | Internal data bit per channel |
| pad_fb | input | N_CH | Pad input buffer level per channel |
| pad_do | output | N_CH | Data value presented to each pad driver |
| pad_oe | output | N_CH | Active-high output enable for each pad driver |

## Verification
A stuck or stale arm flag shows as a burst where none should occur, or as a missing one. It appears at pad_oe in the first cycle after a rising data bit, or as a repeated burst while the data stays high. A burst counter that is off by one changes the pulse length by a clock, and this is visible exactly drive_cap cycles after the data edge. A synchronizer that is too shallow or too deep moves the clocked-mode release by one cycle relative to pad_fb. The scenarios therefore check every cycle of each burst, not just its start.

// File: rtl/qod_pkg.sv
package qod_pkg;
  typedef enum logic {
    FB_DIRECT  = 1'b0,
    FB_CLOCKED = 1'b1
  } fb_mode_e;
endpackage

// File: rtl/qod_sync.sv
module qod_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // Idle line reads high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qod_burst.sv
module qod_burst #(
  parameter int CAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             data,
  input  logic             fb_now,
  input  logic [CAP_W-1:0] cap,
  output logic             drive_hi
);
  logic             armed;
  logic [CAP_W-1:0] cnt;
  logic [CAP_W:0]   nxt;

  assign nxt      = {1'b0, cnt} + {{CAP_W{1'b0}}, 1'b1};
  assign drive_hi = data & armed & (cnt < cap) & ~fb_now;

  // Arm while data is low; burn down while data is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!data) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed) begin
      cnt <= nxt[CAP_W-1:0];
      if (fb_now || (nxt >= {1'b0, cap})) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/qod_accel.sv
module qod_accel #(
  parameter int N_CH        = 4,
  parameter int CAP_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic [CAP_W-1:0] drive_cap,
  input  logic [N_CH-1:0]  data_in,
  input  logic [N_CH-1:0]  pad_fb,
  output logic [N_CH-1:0]  pad_do,
  output logic [N_CH-1:0]  pad_oe
);
  import qod_pkg::*;

  fb_mode_e        mode;
  logic [N_CH-1:0] fb_sync;
  logic [N_CH-1:0] fb_sel;
  logic [N_CH-1:0] drive_hi;

  assign mode = fb_mode_e'(mode_sel);

  qod_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_fb),
    .q   (fb_sync)
  );

  assign fb_sel = (mode == FB_CLOCKED) ? fb_sync : pad_fb;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    qod_burst #(.CAP_W(CAP_W)) u_burst (
      .clk      (clk),
      .rst      (rst),
      .data     (data_in[i]),
      .fb_now   (fb_sel[i]),
      .cap      (drive_cap),
      .drive_hi (drive_hi[i])
    );
  end

  assign pad_do = rst ? '1 : data_in;
  assign pad_oe = rst ? '0 : (~data_in | drive_hi);
endmodule

// File: rtl/qod_accel_chk.sv
module qod_accel_chk #(
  parameter int N_CH  = 4,
  parameter int CAP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CAP_W-1:0] drive_cap,
  input logic [N_CH-1:0]  data_in,
  input logic [N_CH-1:0]  pad_do,
  input logic [N_CH-1:0]  pad_oe
);
  logic [N_CH-1:0] hd;
  assign hd = pad_oe & pad_do;

  assert_low_drives_R1: assert property (@(posedge clk) disable iff (rst)
    ((~data_in & ~pad_oe) == '0) && ((~data_in & pad_do) == '0));

  assert_data_passes_R2: assert property (@(posedge clk) disable iff (rst)
    pad_do == data_in);

  always_comb begin
    if (rst) assert_reset_released_R3: assert (pad_oe == '0 && pad_do == '1);
  end

  assert_zero_cap_R9: assert property (@(posedge clk) disable iff (rst)
    (drive_cap == '0) |-> (hd == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CAP_W:0] run;
    always_ff @(posedge clk) begin
      if (rst)                run <= '0;
      else if (!hd[i])        run <= '0;
      else if (run != '1)     run <= run + {{CAP_W{1'b0}}, 1'b1};
    end

    assert_burst_cap_R7: assert property (@(posedge clk) disable iff (rst)
      hd[i] |-> (run < {1'b0, drive_cap}));

    assert_no_redrive_R8: assert property (@(posedge clk) disable iff (rst)
      (data_in[i] && $past(data_in[i]) && !$past(hd[i]) && !$past(rst)) |-> !hd[i]);
  end
endmodule

bind qod_accel qod_accel_chk #(.N_CH(N_CH), .CAP_W(CAP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drive_cap (drive_cap),
  .data_in   (data_in),
  .pad_do    (pad_do),
  .pad_oe    (pad_oe)
);

// File: tb/qod_accel_tb.sv
module qod_accel_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sel = 1'b0;
  logic [3:0] drive_cap = 4'd1;
  logic [3:0] data_in = 4'b0000;
  logic [3:0] pad_fb = 4'b0000;
  logic [3:0] pad_do;
  logic [3:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] q_oe [$];
  logic [3:0] q_do [$];
  string      q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qod_accel #(.N_CH(4), .CAP_W(4), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .drive_cap (drive_cap),
    .data_in   (data_in),
    .pad_fb    (pad_fb),
    .pad_do    (pad_do),
    .pad_oe    (pad_oe)
  );

  // Driver: one call = one clock cycle of stimulus plus its expected outputs.
  task automatic step(input logic r, input logic m, input logic [3:0] cap,
                      input logic [3:0] d, input logic [3:0] f,
                      input logic [3:0] eo, input logic [3:0] ed, input string tag);
    @(negedge clk);
    rst = r; mode_sel = m; drive_cap = cap; data_in = d; pad_fb = f;
    q_oe.push_back(eo);
    q_do.push_back(ed);
    q_tag.push_back(tag);
  endtask

  // Monitor: samples a quarter period after the driver, before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q_oe.size() != 0) begin
        logic [3:0] eo, ed;
        string t;
        eo = q_oe.pop_front();
        ed = q_do.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (pad_oe !== eo || pad_do !== ed) begin
          errors++;
          $display("FAIL %s pad_oe=%b expected %b pad_do=%b expected %b", t, pad_oe, eo, pad_do, ed);
        end
      end
    end
  end

  initial begin
    // Reset state (R3)
    step(1, 0, 4'd1, 4'b0000, 4'b0000, 4'b0000, 4'b1111, "R3");
    step(1, 0, 4'd1, 4'b1111, 4'b1111, 4'b0000, 4'b1111, "R3");
    step(0, 0, 4'd1, 4'b1111, 4'b1111, 4'b0000, 4'b1111, "R3");
    // Direct mode, cap 1
    step(0, 0, 4'd1, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 0, 4'd1, 4'b0001, 4'b0000, 4'b1111, 4'b0001, "R4");
    step(0, 0, 4'd1, 4'b0001, 4'b0000, 4'b1110, 4'b0001, "R7");
    // Direct mode, cap 4, release on feedback
    step(0, 0, 4'd4, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 0, 4'd4, 4'b0001, 4'b0000, 4'b1111, 4'b0001, "R4");
    step(0, 0, 4'd4, 4'b0001, 4'b0001, 4'b1110, 4'b0001, "R4");
    step(0, 0, 4'd4, 4'b0001, 4'b0000, 4'b1110, 4'b0001, "R8");
    // Clocked mode, cap 1
    step(0, 1, 4'd1, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd1, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd1, 4'b0001, 4'b0000, 4'b1111, 4'b0001, "R5");
    step(0, 1, 4'd1, 4'b0001, 4'b0000, 4'b1110, 4'b0001, "R5");
    // Clocked mode, synchronizer delay
    step(0, 1, 4'd15, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd15, 4'b0001, 4'b0001, 4'b1111, 4'b0001, "R6");
    step(0, 1, 4'd15, 4'b0001, 4'b0001, 4'b1111, 4'b0001, "R6");
    step(0, 1, 4'd15, 4'b0001, 4'b0001, 4'b1110, 4'b0001, "R6");
    // Zero cap in both modes
    step(0, 1, 4'd0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd0, 4'b0001, 4'b0000, 4'b1110, 4'b0001, "R9");
    step(0, 0, 4'd0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 0, 4'd0, 4'b0001, 4'b0000, 4'b1110, 4'b0001, "R9");
    // Independent channels, clocked, cap 3
    step(0, 1, 4'd3, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd3, 4'b0000, 4'b0000, 4'b1111, 4'b0000, "R1");
    step(0, 1, 4'd3, 4'b0101, 4'b0100, 4'b1111, 4'b0101, "R10");
    step(0, 1, 4'd3, 4'b0101, 4'b0100, 4'b1111, 4'b0101, "R10");
    step(0, 1, 4'd3, 4'b0101, 4'b0100, 4'b1011, 4'b0101, "R10");
    step(0, 1, 4'd3, 4'b0101, 4'b0100, 4'b1010, 4'b0101, "R7");
    step(0, 1, 4'd3, 4'b1010, 4'b1010, 4'b1111, 4'b1010, "R2");
    // Reset in mid-run
    step(1, 1, 4'd3, 4'b1010, 4'b1010, 4'b0000, 4'b1111, "R3");
    step(0, 1, 4'd3, 4'b1010, 4'b1010, 4'b0101, 4'b1010, "R3");
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule